// File: doc/BRIEF.md
# Pipelined Synchronous SRAM Without Bus Turnaround

This block is a small on-chip synchronous memory with a registered, two-stage pipelined interface. Address and command are presented on one clock edge. The data for that access moves across the data bus a fixed number of enabled edges later. Write data and read data lag their commands by the same amount, so the bus carries one beat per enabled cycle and never needs an idle cycle when the traffic switches between reads and writes.

An active-low clock enable qualifies every edge. When it is high, the edge is treated as if it never happened, and every pending operation is held in place. Three chip-select inputs, with mixed polarities, must all be in their active state for a new access to start. A burst-continue input reuses the last operation type and advances a 2-bit wrap counter inside a 4-word block. A sleep request takes effect only on a cycle that selects nothing. While the block sleeps, every command is turned into a no-operation.

Top module: `pipe_sram`

## Requirements
- R1: Inputs are captured only on rising edges where `clk_en_n` is 0. On an edge with `clk_en_n` at 1, `q` and `q_oe` hold their values, no memory word changes, and every queued operation completes later exactly as if that edge had not occurred.
- R2: A new access starts only when `sel1_n`=0, `sel2`=1 and `sel3_n`=0. Every other combination, without `adv`, is a no-operation. Two enabled edges after a no-operation command, `q_oe` is 0 and `q` is all zeros.
- R3: A read command has `we_n`=1. After the second enabled edge that follows the command edge, `q` holds the addressed word and `q_oe` is 1.
- R4: A write command has `we_n`=0. Its byte enables `be_n` are sampled with the command, and bit i is active low. The data is taken from `wdata` on the second enabled edge after the command. Byte lane i, which is bits 8i+7..8i, is written only when `be_n[i]` is 0. The other lanes keep their old contents.
- R5: Reads and writes may follow each other on consecutive enabled edges in any order, with no idle cycles. A read issued after a write to the same address returns the newly written data.
- R6: With `adv`=1, the block ignores `addr`, `we_n` and the three selects. It repeats the type of the previous operation at an address whose upper bits stay the same and whose two low bits are incremented modulo 4. `be_n` is still sampled on each beat.
- R7: With `adv`=1, if the previous enabled cycle was a no-operation (deselected or asleep), the new cycle is also a no-operation.
- R8: If `sleep`=1 on an enabled edge whose command, before sleep is taken into account, is a no-operation, the block goes to sleep. It stays asleep for as long as `sleep` remains 1 on enabled edges. While asleep, every command is a no-operation. A `sleep` of 1 that comes with a starting read or write has no effect on that access.
- R9: While `rst_n` is low, `q_oe`=0 and `q` is zero. The pipeline restarts empty and awake, and the previous operation counts as a no-operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en_n | input | 1 | Active-low edge qualifier |
| sel1_n | input | 1 | Select, active low |
| sel2 | input | 1 | Select, active high |
| sel3_n | input | 1 | Select, active low |
| we_n | input | 1 | 0 = write, 1 = read |
| adv | input | 1 | Continue the burst from the internal counter |
| sleep | input | 1 | Sleep request |
| addr | input | AW | Word address |
| be_n | input | NB | Byte write enables, active low |
| wdata | input | NB*BW | Write data, two enabled edges after its command |
| q | output | NB*BW | Read data, zero when not driving |
| q_oe | output | 1 | High when `q` carries read data |

## Verification
A wrong stage register or an edge that was not frozen moves data by one beat. The next read then returns the neighbour's word, or `q_oe` goes high on the wrong cycle, visible two enabled edges after the faulty command. A corrupted burst counter or byte mask does not show until the affected word is read back. For this reason the sweep fills every word first and then reads at random addresses often, so a stale or misplaced byte appears within a few dozen cycles. A sleep or deselect that is mishandled shows as `q_oe` set when it should be clear, or the reverse, two enabled edges later.

// File: rtl/sram_pkg.sv
package sram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;

  // width of the wrapping part of the burst address
  localparam int BURST_LOG2 = 2;
endpackage

// File: rtl/sram_cmd_decode.sv
module sram_cmd_decode
  import sram_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          sel1_n,
  input  logic          sel2,
  input  logic          sel3_n,
  input  logic          we_n,
  input  logic          adv,
  input  logic          sleep,
  input  logic [AW-1:0] addr,
  output op_e           cmd_op,
  output logic [AW-1:0] cmd_addr
);
  localparam int LO = BURST_LOG2;

  op_e           last_op_q, last_op_d, raw_op;
  logic [AW-1:0] last_addr_q, last_addr_d;
  logic          asleep_q, asleep_d;
  logic          selected;

  always_comb begin
    selected = !sel1_n && sel2 && !sel3_n;
    raw_op   = OP_IDLE;
    cmd_addr = addr;
    if (adv) begin
      raw_op   = last_op_q;
      cmd_addr = {last_addr_q[AW-1:LO], last_addr_q[LO-1:0] + LO'(1)};
    end else if (selected) begin
      raw_op = we_n ? OP_RD : OP_WR;
    end
    cmd_op      = asleep_q ? OP_IDLE : raw_op;
    asleep_d    = sleep && (asleep_q || (raw_op == OP_IDLE));
    last_op_d   = cmd_op;
    last_addr_d = (cmd_op != OP_IDLE) ? cmd_addr : last_addr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_op_q   <= OP_IDLE;
      last_addr_q <= '0;
      asleep_q    <= 1'b0;
    end else if (en) begin
      last_op_q   <= last_op_d;
      last_addr_q <= last_addr_d;
      asleep_q    <= asleep_d;
    end
  end

  // R6
  burst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && adv && !asleep_q && (last_op_q != OP_IDLE)) |=>
      (last_addr_q[LO-1:0] == $past(last_addr_q[LO-1:0]) + LO'(1)));

  // R8
  sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep_q) |-> $past(sleep && en));
endmodule

// File: rtl/sram_pipe.sv
module sram_pipe
  import sram_pkg::*;
#(
  parameter int AW  = 4,
  parameter int NB  = 2,
  parameter int LAT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  op_e           cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  logic [NB-1:0] cmd_be_n,
  output op_e           ex_op,
  output logic [AW-1:0] ex_addr,
  output logic [NB-1:0] ex_be_n
);
  op_e           op_q   [LAT];
  logic [AW-1:0] addr_q [LAT];
  logic [NB-1:0] be_q   [LAT];

  for (genvar i = 0; i < LAT; i++) begin : g_stage
    op_e           op_d;
    logic [AW-1:0] addr_d;
    logic [NB-1:0] be_d;

    if (i == 0) begin : g_head
      always_comb begin
        op_d   = cmd_op;
        addr_d = cmd_addr;
        be_d   = cmd_be_n;
      end
    end else begin : g_body
      always_comb begin
        op_d   = op_q[i-1];
        addr_d = addr_q[i-1];
        be_d   = be_q[i-1];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        op_q[i]   <= OP_IDLE;
        addr_q[i] <= '0;
        be_q[i]   <= '1;
      end else if (en) begin
        op_q[i]   <= op_d;
        addr_q[i] <= addr_d;
        be_q[i]   <= be_d;
      end
    end
  end

  assign ex_op   = op_q[LAT-1];
  assign ex_addr = addr_q[LAT-1];
  assign ex_be_n = be_q[LAT-1];

  // R1
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(ex_op) && $stable(ex_addr) && $stable(ex_be_n)));
endmodule

// File: rtl/sram_array.sv
module sram_array
  import sram_pkg::*;
#(
  parameter int AW = 4,
  parameter int NB = 2,
  parameter int BW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  op_e              ex_op,
  input  logic [AW-1:0]    ex_addr,
  input  logic [NB-1:0]    ex_be_n,
  input  logic [NB*BW-1:0] wdata,
  output logic [NB*BW-1:0] q,
  output logic             q_oe
);
  localparam int DEPTH = 1 << AW;
  localparam int DW    = NB * BW;

  logic [DW-1:0] rd_word;
  logic [DW-1:0] q_d;
  logic          oe_d;
  logic          wr_fire;

  assign wr_fire = en && (ex_op == OP_WR);

  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic [BW-1:0] lane [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_fire && !ex_be_n[b]) begin
        lane[ex_addr] <= wdata[b*BW +: BW];
      end
    end

    assign rd_word[b*BW +: BW] = lane[ex_addr];
  end

  always_comb begin
    if (ex_op == OP_RD) begin
      q_d  = rd_word;
      oe_d = 1'b1;
    end else begin
      q_d  = '0;
      oe_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q    <= '0;
      q_oe <= 1'b0;
    end else if (en) begin
      q    <= q_d;
      q_oe <= oe_d;
    end
  end

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (ex_op != OP_RD)) |=> (!q_oe && (q == '0)));
endmodule

// File: rtl/pipe_sram.sv
module pipe_sram
  import sram_pkg::*;
#(
  parameter int AW  = 4,
  parameter int NB  = 2,
  parameter int BW  = 8,
  parameter int LAT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en_n,
  input  logic             sel1_n,
  input  logic             sel2,
  input  logic             sel3_n,
  input  logic             we_n,
  input  logic             adv,
  input  logic             sleep,
  input  logic [AW-1:0]    addr,
  input  logic [NB-1:0]    be_n,
  input  logic [NB*BW-1:0] wdata,
  output logic [NB*BW-1:0] q,
  output logic             q_oe
);
  logic          en;
  op_e           cmd_op;
  logic [AW-1:0] cmd_addr;
  op_e           ex_op;
  logic [AW-1:0] ex_addr;
  logic [NB-1:0] ex_be_n;

  assign en = !clk_en_n;

  sram_cmd_decode #(.AW(AW)) u_dec (
    .clk(clk), .rst_n(rst_n), .en(en),
    .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
    .we_n(we_n), .adv(adv), .sleep(sleep), .addr(addr),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr)
  );

  sram_pipe #(.AW(AW), .NB(NB), .LAT(LAT)) u_pipe (
    .clk(clk), .rst_n(rst_n), .en(en),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_be_n(be_n),
    .ex_op(ex_op), .ex_addr(ex_addr), .ex_be_n(ex_be_n)
  );

  sram_array #(.AW(AW), .NB(NB), .BW(BW)) u_mem (
    .clk(clk), .rst_n(rst_n), .en(en),
    .ex_op(ex_op), .ex_addr(ex_addr), .ex_be_n(ex_be_n),
    .wdata(wdata), .q(q), .q_oe(q_oe)
  );

  // R3
  oe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q_oe) |-> $past(!clk_en_n));
endmodule

// File: tb/sim_pipe_sram.sv
module sim_pipe_sram;
  localparam int AW    = 4;
  localparam int NB    = 2;
  localparam int BW    = 8;
  localparam int DW    = NB * BW;
  localparam int DEPTH = 1 << AW;

  typedef enum int {M_IDLE, M_RD, M_WR} mop_t;

  logic          clk = 1'b0;
  logic          rst_n, clk_en_n, sel1_n, sel2, sel3_n, we_n, adv, sleep;
  logic [AW-1:0] addr;
  logic [NB-1:0] be_n;
  logic [DW-1:0] wdata, q;
  logic          q_oe;

  always #2 clk = ~clk;

  pipe_sram u0 (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n),
    .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
    .we_n(we_n), .adv(adv), .sleep(sleep), .addr(addr),
    .be_n(be_n), .wdata(wdata), .q(q), .q_oe(q_oe)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [DW-1:0] ref_mem [DEPTH];
  bit            part_w  [DEPTH];
  int            wr_edge [DEPTH];
  mop_t          p_op    [2];
  logic [AW-1:0] p_addr  [2];
  logic [NB-1:0] p_be    [2];
  bit            p_bst   [2];
  string         p_tag   [2];
  mop_t          lop;
  logic [AW-1:0] laddr;
  bit            slp;
  int            edge_n, fill, hold;
  logic [DW-1:0] exp_q;
  logic          exp_oe;
  string         exp_tag;

  task automatic check(input string tag);
    checks++;
    if (q !== exp_q || q_oe !== exp_oe) begin
      fails++;
      $display("FAIL %s: q=%h q_oe=%b expected q=%h q_oe=%b", tag, q, q_oe, exp_q, exp_oe);
    end
  endtask

  // one enabled edge, using the inputs still applied
  task automatic model_edge();
    mop_t raw, nop;
    logic [AW-1:0] na;
    bit bst;
    string tg;
    logic [AW-1:0] a;
    a = p_addr[1];
    if (p_op[1] == M_WR) begin
      for (int b = 0; b < NB; b++)
        if (!p_be[1][b]) ref_mem[a][b*BW +: BW] = wdata[b*BW +: BW];
      part_w[a]  = (p_be[1] != '0);
      wr_edge[a] = edge_n;
    end
    if (p_op[1] == M_RD) begin
      exp_q  = ref_mem[a];
      exp_oe = 1'b1;
      if (p_bst[1])                    exp_tag = "R6";
      else if (part_w[a])              exp_tag = "R4";
      else if (wr_edge[a] >= edge_n-1) exp_tag = "R5";
      else                             exp_tag = "R3";
    end else begin
      exp_q   = '0;
      exp_oe  = 1'b0;
      exp_tag = p_tag[1];
    end
    p_op[1] = p_op[0]; p_addr[1] = p_addr[0]; p_be[1] = p_be[0];
    p_bst[1] = p_bst[0]; p_tag[1] = p_tag[0];
    raw = M_IDLE; na = addr; bst = 0; tg = "R2";
    if (adv) begin
      raw = lop;
      na  = {laddr[AW-1:2], laddr[1:0] + 2'd1};
      bst = 1;
      tg  = "R7";
    end else if (!sel1_n && sel2 && !sel3_n) begin
      raw = we_n ? M_RD : M_WR;
    end
    nop = slp ? M_IDLE : raw;
    if (slp) tg = "R8";
    slp = sleep && (slp || raw == M_IDLE);
    lop = nop;
    if (nop != M_IDLE) laddr = na;
    p_op[0] = nop; p_addr[0] = na; p_be[0] = be_n;
    p_bst[0] = bst && (nop != M_IDLE); p_tag[0] = tg;
    edge_n++;
  endtask

  task automatic drive(input int cyc);
    int kind, c;
    logic [2:0] v;
    clk_en_n = (cyc > 4) && ($urandom % 6 == 0);
    wdata  = DW'($urandom);
    sel1_n = 1'b0; sel2 = 1'b1; sel3_n = 1'b0;
    adv = 1'b0; we_n = 1'b1;
    addr = AW'($urandom);
    be_n = NB'($urandom);
    if (fill < DEPTH) begin
      we_n = 1'b0; addr = AW'(fill); be_n = '0;
      if (!clk_en_n) fill++;
    end else begin
      kind = int'($urandom % 16);
      if (kind <= 4) begin
        we_n = 1'b1;
      end else if (kind <= 8) begin
        we_n = 1'b0; be_n = '0;
      end else if (kind <= 11) begin
        adv = 1'b1;
        we_n = 1'($urandom);
        {sel1_n, sel2, sel3_n} = 3'($urandom);
      end else if (kind <= 13) begin
        c = int'($urandom % 7);
        v = 3'(c < 2 ? c : c + 1);
        {sel1_n, sel2, sel3_n} = v;
        if (kind == 13) hold = 5;
      end else if (kind == 14) begin
        we_n = 1'b1;
      end else begin
        we_n = 1'b0;
      end
    end
    sleep = (hold > 0);
    if (hold > 0) hold--;
  endtask

  initial begin
    rst_n = 1'b0; clk_en_n = 1'b0; sel1_n = 1'b1; sel2 = 1'b0; sel3_n = 1'b1;
    we_n = 1'b1; adv = 1'b0; sleep = 1'b0; addr = '0; be_n = '1; wdata = '0;
    for (int i = 0; i < 2; i++) begin
      p_op[i] = M_IDLE; p_addr[i] = '0; p_be[i] = '1; p_bst[i] = 0; p_tag[i] = "R9";
    end
    for (int i = 0; i < DEPTH; i++) begin
      ref_mem[i] = '0; part_w[i] = 0; wr_edge[i] = -10;
    end
    lop = M_IDLE; laddr = '0; slp = 0; edge_n = 0; fill = 0; hold = 0;
    exp_q = '0; exp_oe = 1'b0; exp_tag = "R9";
    repeat (3) @(negedge clk);
    check("R9");
    rst_n = 1'b1;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      drive(cyc);
      @(negedge clk);
      if (!clk_en_n) begin
        model_edge();
        check(exp_tag);
      end else begin
        check("R1");
      end
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule